// File: doc/BRIEF.md
# Two-Level Page Walker with Translation Cache

This block turns a 32-bit linear address into a physical address for one requester at a time. When paging is switched on, it first looks in a small fully associative translation cache. If no entry matches, it reads a first-level directory entry from memory and then, for 4 KB pages, a second-level table entry. The base of the directory comes from a root register. An optional size-extension mode lets a directory entry map a 4 MB frame directly. Every access is checked for presence, write permission and user permission. A violation returns a fault that carries the linear address.

Software programs two control registers through a one-cycle write port. Select 0 holds the mode flags. Select 1 holds the root frame. Any write to the root register empties the translation cache. Translation requests use a valid/ready handshake, and each produces a one-cycle response. Memory is reached through a read port that allows one outstanding read. The memory answers with a one-cycle `mem_rvalid` pulse some cycles after each `mem_req` pulse.

The controller is a single state machine with these states:
- ST_IDLE: ready for a request. A valid request moves the machine to ST_LOOK.
- ST_LOOK: checks the paging flag and the cache. With paging off, or on a cache hit, the machine goes to ST_RESP. Otherwise it goes to ST_DIR_REQ.
- ST_DIR_REQ: issues the directory read and moves to ST_DIR_WAIT.
- ST_DIR_WAIT: waits for the directory data. A non-present entry or a large-page entry leads to ST_RESP. Any other entry leads to ST_TBL_REQ.
- ST_TBL_REQ: issues the table read and moves to ST_TBL_WAIT.
- ST_TBL_WAIT: waits for the table data, then moves to ST_RESP.
- ST_RESP: presents the result for one cycle and returns to ST_IDLE.

Top module: `xlat_walker`

## Requirements
- R1: While mode bit 0 (paging enable, control select 0) is 0, a request returns its linear address unchanged with no fault and issues no memory read.
- R2: With paging on and no cached match, the walker reads the directory word at {root[31:12], laddr[31:22], 2'b00}. For a non-large entry it then reads the table word at {dir[31:12], laddr[21:12], 2'b00}. The result is {tbl[31:12], laddr[11:0]}.
- R3: When mode bit 1 (size extension) is 1 and directory bit 7 is 1, only the directory is read and the result is {dir[31:22], laddr[21:0]}. When mode bit 1 is 0, directory bit 7 is ignored and the second-level read still takes place.
- R4: An entry with bit 0 (present) clear, at either level, ends the walk with rsp_fault=1 and rsp_addr equal to the linear address.
- R5: A write faults unless bit 1 (writable) is set in every entry used for the translation. Reads ignore bit 1.
- R6: A user-mode access faults unless bit 2 (user) is set in every entry used. Supervisor accesses ignore bit 2.
- R7: A request that matches a cached translation issues no memory read and responds on the second cycle after acceptance. The permission checks of R5 and R6 still apply.
- R8: A cached 4 MB entry matches any address with the same bits 31:22. A cached 4 KB entry matches only the same bits 31:12.
- R9: The cache holds 8 translations and fills them in round-robin order from slot 0. When all slots are full, the slot written longest ago is replaced, and the order restarts at slot 0 after an invalidation.
- R10: A write to the root register (control select 1) invalidates every cached translation. A write to the mode register leaves them intact.
- R11: A walk that ends in a fault installs nothing, so repeating the access walks again.
- R12: After reset req_ready=1, rsp_valid=0 and mem_req=0. req_ready is high only while idle, rsp_valid lasts one cycle, and at most one memory read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_sel | input | 1 | 0: mode flags (bit 0 paging, bit 1 size extension); 1: root register (bits 31:12) |
| ctl_wdata | input | 32 | Control write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for a user-mode access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 32 | Physical address, or the linear address on a fault |
| rsp_fault | output | 1 | Page fault indication |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Memory read word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Translations are exercised with several kinds of input:
- Paging switched off, which checks that addresses pass straight through.
- Cold walks through 4 KB and 4 MB mappings, which check each read address and how the result is assembled.
- Repeats of the same access, which separate cache hits from walks by their read count and latency.
- Entries that deny writes or user access at either level, plus non-present entries, which check each fault cause and that faults are not cached.
- A run of nine distinct pages after a root write, which checks replacement order and invalidation.

A behavioural model in the bench keeps its own cache image and predicts, for every request, the result, the fault, the read addresses and the cycle of the response.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // Entry flag positions shared by both table levels
    localparam int unsigned ENT_P  = 0;
    localparam int unsigned ENT_W  = 1;
    localparam int unsigned ENT_U  = 2;
    localparam int unsigned ENT_PS = 7;

    // Control register selects and mode bit positions
    localparam logic        CTL_SEL_MODE = 1'b0;
    localparam logic        CTL_SEL_ROOT = 1'b1;
    localparam int unsigned MODE_PG      = 0;
    localparam int unsigned MODE_PSE     = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_RESP
    } walk_state_e;

    typedef struct packed {
        logic [19:0] tag;
        logic [19:0] ppn;
        logic        big;
        logic        wr;
        logic        usr;
    } tlb_ent_t;

endpackage

// File: rtl/xlat_perm.sv
module xlat_perm (
    input  logic present,
    input  logic wr_ok,
    input  logic usr_ok,
    input  logic acc_wr,
    input  logic acc_usr,
    output logic fault
);

    assign fault = !present || (acc_wr && !wr_ok) || (acc_usr && !usr_ok);

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int unsigned ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic [19:0] lk_vpn,
    output logic        lk_hit,
    output tlb_ent_t    lk_ent,
    input  logic        ins_en,
    input  tlb_ent_t    ins_ent
);

    localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_ent_t           ent_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] match;
    logic [PTR_W-1:0]   rr_q;

    // Per-entry compare; a large entry ignores the low ten tag bits
    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = vld_q[g] &&
                (ent_q[g].big ? (ent_q[g].tag[19:10] == lk_vpn[19:10])
                              : (ent_q[g].tag == lk_vpn));
        end
    endgenerate

    // Lowest matching slot wins
    always_comb begin
        lk_hit = |match;
        lk_ent = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) lk_ent = ent_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            rr_q  <= '0;
        end else if (flush) begin
            vld_q <= '0;
            rr_q  <= '0;
        end else if (ins_en) begin
            vld_q[rr_q] <= 1'b1;
            rr_q        <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en && !flush) ent_q[rr_q] <= ins_ent;
    end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
#(
    parameter int unsigned TLB_ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic        ctl_sel,
    input  logic [31:0] ctl_wdata,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_laddr,
    input  logic        req_write,
    input  logic        req_user,
    output logic        rsp_valid,
    output logic [31:0] rsp_addr,
    output logic        rsp_fault,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata
);

    walk_state_e st_q, st_d;

    logic [19:0] root_q;
    logic        pg_q, pse_q;
    logic [31:0] la_q;
    logic        wr_q, us_q;
    logic [31:0] pde_q;
    logic [31:0] res_addr_q;
    logic        res_fault_q;
    logic        stale_q;

    logic        root_wr;
    logic        tlb_hit;
    tlb_ent_t    tlb_ent, ins_ent;
    logic        ins_en;
    logic        chk_p, chk_w, chk_u, chk_fault;
    logic        big_sel;
    logic        fin_walk;
    logic [31:0] hit_pa, walk_pa;
    logic        unused_bits;

    assign root_wr = ctl_we && (ctl_sel == CTL_SEL_ROOT);
    assign big_sel = pse_q && mem_rdata[ENT_PS];

    assign unused_bits = ^{ctl_wdata[11:2], pde_q[11:3], pde_q[ENT_P],
                           mem_rdata[11:8], mem_rdata[6:3], tlb_ent.tag};

    xlat_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (root_wr),
        .lk_vpn  (la_q[31:12]),
        .lk_hit  (tlb_hit),
        .lk_ent  (tlb_ent),
        .ins_en  (ins_en),
        .ins_ent (ins_ent)
    );

    xlat_perm u_perm (
        .present (chk_p),
        .wr_ok   (chk_w),
        .usr_ok  (chk_u),
        .acc_wr  (wr_q),
        .acc_usr (us_q),
        .fault   (chk_fault)
    );

    // Flags fed to the permission check, chosen by where the walk stands
    always_comb begin
        chk_p = 1'b1;
        chk_w = tlb_ent.wr;
        chk_u = tlb_ent.usr;
        unique case (st_q)
            ST_DIR_WAIT: begin
                chk_p = mem_rdata[ENT_P];
                chk_w = mem_rdata[ENT_W];
                chk_u = mem_rdata[ENT_U];
            end
            ST_TBL_WAIT: begin
                chk_p = mem_rdata[ENT_P];
                chk_w = pde_q[ENT_W] & mem_rdata[ENT_W];
                chk_u = pde_q[ENT_U] & mem_rdata[ENT_U];
            end
            default: ;
        endcase
    end

    always_comb begin
        hit_pa  = tlb_ent.big ? {tlb_ent.ppn[19:10], la_q[21:0]}
                              : {tlb_ent.ppn, la_q[11:0]};
        walk_pa = (st_q == ST_DIR_WAIT) ? {mem_rdata[31:22], la_q[21:0]}
                                        : {mem_rdata[31:12], la_q[11:0]};
    end

    assign fin_walk = mem_rvalid &&
        (((st_q == ST_DIR_WAIT) && (!mem_rdata[ENT_P] || big_sel)) ||
         (st_q == ST_TBL_WAIT));

    always_comb begin
        ins_en      = fin_walk && !chk_fault && !stale_q && !root_wr;
        ins_ent.tag = la_q[31:12];
        ins_ent.ppn = mem_rdata[31:12];
        ins_ent.big = (st_q == ST_DIR_WAIT);
        ins_ent.wr  = chk_w;
        ins_ent.usr = chk_u;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (req_valid) st_d = ST_LOOK;
            ST_LOOK:     st_d = (!pg_q || tlb_hit) ? ST_RESP : ST_DIR_REQ;
            ST_DIR_REQ:  st_d = ST_DIR_WAIT;
            ST_DIR_WAIT: if (mem_rvalid)
                             st_d = (!mem_rdata[ENT_P] || big_sel) ? ST_RESP : ST_TBL_REQ;
            ST_TBL_REQ:  st_d = ST_TBL_WAIT;
            ST_TBL_WAIT: if (mem_rvalid) st_d = ST_RESP;
            ST_RESP:     st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Outputs
    always_comb begin
        req_ready = (st_q == ST_IDLE);
        rsp_valid = (st_q == ST_RESP);
        rsp_addr  = res_addr_q;
        rsp_fault = res_fault_q;
        mem_req   = (st_q == ST_DIR_REQ) || (st_q == ST_TBL_REQ);
        mem_addr  = (st_q == ST_TBL_REQ) ? {pde_q[31:12], la_q[21:12], 2'b00}
                                         : {root_q, la_q[31:22], 2'b00};
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            root_q      <= '0;
            pg_q        <= 1'b0;
            pse_q       <= 1'b0;
            la_q        <= '0;
            wr_q        <= 1'b0;
            us_q        <= 1'b0;
            pde_q       <= '0;
            res_addr_q  <= '0;
            res_fault_q <= 1'b0;
            stale_q     <= 1'b0;
        end else begin
            if (ctl_we) begin
                if (ctl_sel == CTL_SEL_ROOT) begin
                    root_q <= ctl_wdata[31:12];
                end else begin
                    pg_q  <= ctl_wdata[MODE_PG];
                    pse_q <= ctl_wdata[MODE_PSE];
                end
            end

            if ((st_q == ST_IDLE) && req_valid) begin
                la_q    <= req_laddr;
                wr_q    <= req_write;
                us_q    <= req_user;
                stale_q <= 1'b0;
            end else if (root_wr) begin
                stale_q <= 1'b1;
            end

            if ((st_q == ST_DIR_WAIT) && mem_rvalid) pde_q <= mem_rdata;

            if (st_q == ST_LOOK) begin
                if (!pg_q) begin
                    res_addr_q  <= la_q;
                    res_fault_q <= 1'b0;
                end else if (tlb_hit) begin
                    res_addr_q  <= chk_fault ? la_q : hit_pa;
                    res_fault_q <= chk_fault;
                end
            end

            if (fin_walk) begin
                res_addr_q  <= chk_fault ? la_q : walk_pa;
                res_fault_q <= chk_fault;
            end
        end
    end

endmodule

// File: rtl/xlat_walker_props.sv
module xlat_walker_props
    import xlat_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_we,
    input logic        ctl_sel,
    input logic [31:0] ctl_wdata,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_laddr,
    input logic        rsp_valid,
    input logic [31:0] rsp_addr,
    input logic        rsp_fault,
    input logic        mem_req,
    input logic        mem_rvalid
);

    logic        pg_sh;
    logic [31:0] lin_q;
    logic        rd_pend;
    logic        unused_ck;

    assign unused_ck = ^ctl_wdata[31:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_sh   <= 1'b0;
            lin_q   <= '0;
            rd_pend <= 1'b0;
        end else begin
            if (ctl_we && (ctl_sel == CTL_SEL_MODE)) pg_sh <= ctl_wdata[0];
            if (req_valid && req_ready) lin_q <= req_laddr;
            if (mem_req)         rd_pend <= 1'b1;
            else if (mem_rvalid) rd_pend <= 1'b0;
        end
    end

    assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !pg_sh) |-> (!rsp_fault && rsp_addr == lin_q));

    assert_no_read_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> pg_sh);

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_addr[11:0] == lin_q[11:0]));

    assert_fault_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_addr == lin_q));

    assert_single_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req) |-> !req_ready);

    assert_one_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !rd_pend);

endmodule

bind xlat_walker xlat_walker_props u_props (.*);

// File: tb/sim_xlat_walker.sv
`timescale 1ns/1ps
module sim_xlat_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_we, ctl_sel;
    logic [31:0] ctl_wdata;
    logic        req_valid, req_ready, req_write, req_user;
    logic [31:0] req_laddr;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_addr;
    logic        mem_req, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    xlat_walker u0 (.*);

    // Memory image and bench-side cache model
    logic [31:0] mem [logic [31:0]];
    bit          m_v [8];
    logic [19:0] m_tag [8];
    logic [19:0] m_ppn [8];
    bit          m_big [8], m_w [8], m_u [8];
    int          m_rr;
    logic [19:0] m_root;
    bit          m_pg, m_pse;

    logic [31:0] rd_q [$];
    bit          pend;
    logic [31:0] pend_a;

    function automatic logic [31:0] rdm(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory responder: one-cycle read latency
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = rdm(pend_a);
            pend       = 1'b0;
        end
        if (rst_n && mem_req) begin
            pend   = 1'b1;
            pend_a = mem_addr;
            rd_q.push_back(mem_addr);
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic predict(input logic [31:0] la, input bit wr, input bit us,
                           output logic [31:0] ea, output bit ef, output int nrd,
                           output logic [31:0] a0, output logic [31:0] a1);
        int hi;
        logic [31:0] pde, pte;
        bit w, u, big;
        logic [19:0] fr;
        nrd = 0; a0 = '0; a1 = '0; ea = la; ef = 0;
        if (!m_pg) return;
        hi = -1;
        for (int i = 0; i < 8; i++)
            if (hi < 0 && m_v[i] && (m_big[i] ? (m_tag[i][19:10] == la[31:22])
                                               : (m_tag[i] == la[31:12]))) hi = i;
        if (hi >= 0) begin
            ef = (wr && !m_w[hi]) || (us && !m_u[hi]);
            if (!ef) ea = m_big[hi] ? {m_ppn[hi][19:10], la[21:0]} : {m_ppn[hi], la[11:0]};
            return;
        end
        a0 = {m_root, la[31:22], 2'b00};
        pde = rdm(a0);
        nrd = 1;
        if (!pde[0]) begin ef = 1; return; end
        if (m_pse && pde[7]) begin
            big = 1; w = pde[1]; u = pde[2]; fr = pde[31:12];
            ea = {pde[31:22], la[21:0]};
        end else begin
            a1 = {pde[31:12], la[21:12], 2'b00};
            pte = rdm(a1);
            nrd = 2;
            if (!pte[0]) begin ef = 1; return; end
            big = 0; w = pde[1] & pte[1]; u = pde[2] & pte[2]; fr = pte[31:12];
            ea = {pte[31:12], la[11:0]};
        end
        ef = (wr && !w) || (us && !u);
        if (ef) begin ea = la; return; end
        m_v[m_rr] = 1; m_tag[m_rr] = la[31:12]; m_ppn[m_rr] = fr;
        m_big[m_rr] = big; m_w[m_rr] = w; m_u[m_rr] = u;
        m_rr = (m_rr + 1) % 8;
    endtask

    task automatic ctl(input bit sel, input logic [31:0] d);
        @(negedge clk);
        ctl_we = 1'b1; ctl_sel = sel; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
        if (sel) begin
            m_root = d[31:12];
            for (int i = 0; i < 8; i++) m_v[i] = 0;
            m_rr = 0;
        end else begin
            m_pg = d[0]; m_pse = d[1];
        end
    endtask

    task automatic xlate(input logic [31:0] la, input bit wr, input bit us, input string rq,
                         output logic [31:0] ga, output bit gf, output int gn);
        logic [31:0] ea, a0, a1;
        bit ef, busy_bad;
        int nrd, lat;
        predict(la, wr, us, ea, ef, nrd, a0, a1);
        rd_q.delete();
        @(negedge clk);
        chk(req_ready === 1'b1, "R12", "ready while idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_laddr = la; req_write = wr; req_user = us;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0; busy_bad = 0;
        while (rsp_valid !== 1'b1 && lat < 60) begin
            if (req_ready !== 1'b0) busy_bad = 1;
            @(negedge clk);
            lat++;
        end
        if (req_ready !== 1'b0) busy_bad = 1;
        ga = rsp_addr; gf = rsp_fault; gn = rd_q.size();
        chk(rsp_addr === ea, rq, "result address", rsp_addr, ea);
        chk(rsp_fault === ef, rq, "fault flag", 32'(rsp_fault), 32'(ef));
        chk(gn == nrd, rq, "memory read count", 32'(gn), 32'(nrd));
        if (nrd >= 1 && gn >= 1) chk(rd_q[0] === a0, rq, "directory read address", rd_q[0], a0);
        if (nrd == 2 && gn == 2) chk(rd_q[1] === a1, rq, "table read address", rd_q[1], a1);
        chk(lat == 1 + 2 * nrd, rq, "response cycle", 32'(lat), 32'(1 + 2 * nrd));
        chk(!busy_bad, "R12", "ready low while busy", 32'(busy_bad), 32'd0);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R12", "response lasts one cycle", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL R12 watchdog expired: actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] ga;
        bit gf;
        int gn;
        rst_n = 1'b0; ctl_we = 1'b0; ctl_sel = 1'b0; ctl_wdata = '0;
        req_valid = 1'b0; req_laddr = '0; req_write = 1'b0; req_user = 1'b0;
        mem_rvalid = 1'b0; mem_rdata = '0; pend = 0; pend_a = '0;
        m_rr = 0; m_root = '0; m_pg = 0; m_pse = 0;
        for (int i = 0; i < 8; i++) m_v[i] = 0;

        // Tables: root at 0x0001_0000
        mem[32'h0001_0004] = 32'h0002_0007;   // dir 1 -> table, P|W|U
        mem[32'h0001_0008] = 32'h0C00_0087;   // dir 2 -> 4 MB, P|W|U
        mem[32'h0001_000C] = 32'h1000_0083;   // dir 3 -> 4 MB, supervisor only
        mem[32'h0001_0014] = 32'h0002_1005;   // dir 5 -> table, read-only
        for (int i = 0; i < 16; i++)
            mem[32'h0002_0000 + 4 * i] = 32'h0030_0007 + (i << 12);
        mem[32'h0002_0014] = 32'h0030_5005;   // page 5 read-only
        mem[32'h0002_0018] = 32'h0030_6003;   // page 6 supervisor only
        mem[32'h0002_001C] = 32'h0000_0000;   // page 7 not present
        mem[32'h0002_1000] = 32'h0050_0007;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R12", "reset ready", 32'(req_ready), 32'd1);
        chk(rsp_valid === 1'b0, "R12", "reset response idle", 32'(rsp_valid), 32'd0);
        chk(mem_req === 1'b0, "R12", "reset no read", 32'(mem_req), 32'd0);

        // R1: paging off
        xlate(32'h1234_5678, 1, 1, "R1", ga, gf, gn);
        chk(ga === 32'h1234_5678 && gn == 0, "R1", "passthrough", ga, 32'h1234_5678);

        ctl(1'b1, 32'h0001_0000);
        ctl(1'b0, 32'h0000_0001);

        // R2 walk, then R7 hit
        xlate(32'h0040_1ABC, 0, 0, "R2", ga, gf, gn);
        chk(ga === 32'h0030_1ABC && gn == 2, "R2", "4 KB walk", ga, 32'h0030_1ABC);
        xlate(32'h0040_1ABC, 1, 1, "R7", ga, gf, gn);
        chk(gn == 0, "R7", "hit without reads", 32'(gn), 32'd0);

        // R3: page-size bit ignored without size extension
        xlate(32'h0080_1234, 0, 0, "R3", ga, gf, gn);
        chk(gf && gn == 2, "R3", "size bit ignored", 32'(gn), 32'd2);

        // R10: mode write keeps cache
        ctl(1'b0, 32'h0000_0003);
        xlate(32'h0040_1ABC, 0, 0, "R10", ga, gf, gn);
        chk(gn == 0, "R10", "mode write keeps entries", 32'(gn), 32'd0);

        xlate(32'h0080_1234, 0, 0, "R3", ga, gf, gn);
        chk(ga === 32'h0C00_1234 && gn == 1, "R3", "4 MB mapping", ga, 32'h0C00_1234);
        xlate(32'h0093_4567, 1, 1, "R8", ga, gf, gn);
        chk(ga === 32'h0C13_4567 && gn == 0, "R8", "4 MB entry covers region", ga, 32'h0C13_4567);
        xlate(32'h0040_0123, 0, 0, "R8", ga, gf, gn);
        chk(gn == 2, "R8", "4 KB entry does not cover neighbour", 32'(gn), 32'd2);

        // R5 / R11: write permission
        xlate(32'h0040_5010, 1, 0, "R5", ga, gf, gn);
        chk(gf === 1'b1, "R5", "write to read-only faults", 32'(gf), 32'd1);
        xlate(32'h0040_5010, 1, 0, "R11", ga, gf, gn);
        chk(gn == 2, "R11", "fault not cached", 32'(gn), 32'd2);
        xlate(32'h0040_5010, 0, 0, "R5", ga, gf, gn);
        chk(!gf && ga === 32'h0030_5010, "R5", "read of read-only", ga, 32'h0030_5010);
        xlate(32'h0040_5010, 1, 0, "R5", ga, gf, gn);
        chk(gf && gn == 0, "R5", "write faults on hit", 32'(gf), 32'd1);
        xlate(32'h0140_0008, 1, 0, "R5", ga, gf, gn);
        chk(gf === 1'b1, "R5", "directory denies write", 32'(gf), 32'd1);
        xlate(32'h0140_0008, 0, 1, "R5", ga, gf, gn);
        chk(!gf && ga === 32'h0050_0008, "R5", "user read allowed", ga, 32'h0050_0008);

        // R6: user permission
        xlate(32'h0040_6004, 0, 1, "R6", ga, gf, gn);
        chk(gf === 1'b1, "R6", "user on supervisor page", 32'(gf), 32'd1);
        xlate(32'h0040_6004, 1, 0, "R6", ga, gf, gn);
        chk(!gf && ga === 32'h0030_6004, "R6", "supervisor allowed", ga, 32'h0030_6004);
        xlate(32'h00C0_0010, 0, 1, "R6", ga, gf, gn);
        chk(gf && gn == 1, "R6", "user on supervisor 4 MB", 32'(gf), 32'd1);

        // R4 / R11: not present
        xlate(32'h0040_7FFC, 0, 0, "R4", ga, gf, gn);
        chk(gf && ga === 32'h0040_7FFC, "R4", "table entry absent", ga, 32'h0040_7FFC);
        xlate(32'h0040_7FFC, 0, 0, "R11", ga, gf, gn);
        chk(gn == 2, "R11", "absent entry walks again", 32'(gn), 32'd2);
        xlate(32'h0100_0044, 0, 0, "R4", ga, gf, gn);
        chk(gf && gn == 1 && ga === 32'h0100_0044, "R4", "directory entry absent", ga, 32'h0100_0044);

        // R10: root write flushes
        ctl(1'b1, 32'h0001_0000);
        xlate(32'h0040_1ABC, 0, 0, "R10", ga, gf, gn);
        chk(gn == 2, "R10", "root write flushes", 32'(gn), 32'd2);

        // R9: round-robin replacement
        ctl(1'b1, 32'h0001_0000);
        for (int p = 8; p < 16; p++) xlate(32'h0040_0000 + (p << 12), 0, 0, "R9", ga, gf, gn);
        xlate(32'h0040_1000, 0, 0, "R9", ga, gf, gn);
        xlate(32'h0040_8000, 0, 0, "R9", ga, gf, gn);
        chk(gn == 2, "R9", "oldest slot replaced", 32'(gn), 32'd2);
        xlate(32'h0040_A000, 0, 0, "R9", ga, gf, gn);
        chk(gn == 0, "R9", "later slot kept", 32'(gn), 32'd0);

        // R1 again: paging off after use
        ctl(1'b0, 32'h0000_0002);
        xlate(32'h0040_1ABC, 1, 1, "R1", ga, gf, gn);
        chk(ga === 32'h0040_1ABC && gn == 0, "R1", "passthrough after disable", ga, 32'h0040_1ABC);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule